// File: doc/BRIEF.md
# Capture and Event Timer

This block is a down-counting timer with two input pins and two companion registers. A small control register selects how it runs. In event counting mode, pin A serves as the count clock: each rising edge lowers the counter by one while the run bit is set. In that mode pin B is a separate rising-edge interrupt source. In capture mode the counter decrements on every system clock. Each companion register then takes a snapshot of the counter when its pin shows the selected edge. Software can read these snapshots at any time without touching the count.

Both pins pass through a synchronizer before their edges are examined. Each pin has a sticky pending flag, and each flag has its own enable. In capture mode the run bit takes on a second role and becomes the underflow pending flag. The pin-A enable gates the underflow interrupt as well as the pin-A capture interrupt. An interrupt on that enable can therefore mean a capture, an underflow, or both.

Control register layout, `ctl`: bits [2:0] mode, bit 3 run/underflow flag, bit 4 enable A, bit 5 enable B, bit 6 pending A, bit 7 pending B. Mode 3'b010 selects event counting. Mode 3'b1xy selects capture, where x sets the pin-A edge and y sets the pin-B edge (0 = rising, 1 = falling). Every other mode value holds the timer idle.

Top module: `cap_timer`

## Requirements
- R1: After reset the counter reads all ones, `ctl_o` reads 0, both capture registers read 0 and `irq_o` is low.
- R2: In an idle mode (any mode value other than 3'b010 and 3'b1xx) the counter holds, and pin activity sets no pending flag and loads no capture register.
- R3: In event mode (3'b010) with bit 3 set, each rising edge on pin A decrements the counter by one. With bit 3 clear, the counter holds.
- R4: In event mode a rising edge on pin B sets pending B (bit 7) and loads no capture register.
- R5: In capture mode (3'b1xx) the counter decrements by one every clock, whatever the value of bit 3, and wraps from zero to all ones.
- R6: In capture mode, pin A's selected edge (mode bit 1: 0 rising, 1 falling) loads `cap_a_o` and sets pending A (bit 6). A pin change set up before clock edge k is captured at edge k+2, and the stored value is the count seen just before that edge. The opposite edge has no effect.
- R7: Pin B behaves as in R6, with polarity taken from mode bit 0, loading `cap_b_o` and setting pending B (bit 7).
- R8: In capture mode, a decrement from zero sets bit 3 as the underflow pending flag.
- R9: Pending flags A, B and (in capture mode) bit 3 stay set until software writes them to 0. A set event in the same cycle as a write of 0 leaves the flag set.
- R10: `irq_o` = (bit 4 AND (pending A OR (capture mode AND bit 3))) OR (bit 5 AND pending B), and it follows the register state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_a_i | input | 1 | Pin A: count clock in event mode, capture trigger A in capture mode |
| pin_b_i | input | 1 | Pin B: interrupt source in event mode, capture trigger B in capture mode |
| ctl_we_i | input | 1 | Write strobe for the control register |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_o | output | 8 | Control register contents |
| cnt_o | output | CNT_W | Current counter value |
| cap_a_o | output | CNT_W | Capture register A |
| cap_b_o | output | CNT_W | Capture register B |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong polarity selection or a misrouted trigger shows up on the same cycle as the stored value or the pending bit: the capture register that should have loaded does not, or the other one loads. A miscounted synchronizer depth moves the captured count away from the value two cycles before the capture by exactly the extra stages, which the comparison spots at once. A broken decrement or event gating shows in `cnt_o` after a few pulses or clocks. A lost underflow or pending set event shows in `ctl_o` and `irq_o` after at most one counter period.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int CTL_W  = 8;
  localparam int B_RUN  = 3;
  localparam int B_EN_A = 4;
  localparam int B_EN_B = 5;
  localparam int B_PN_A = 6;
  localparam int B_PN_B = 7;

  typedef enum logic [1:0] {MK_IDLE, MK_EVENT, MK_CAPTURE} mode_kind_e;

  function automatic mode_kind_e decode_mode(input logic [2:0] m);
    if (m[2])              return MK_CAPTURE;
    else if (m == 3'b010)  return MK_EVENT;
    else                   return MK_IDLE;
  endfunction
endpackage

// File: rtl/cap_timer_sync_edge.sv
module cap_timer_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/cap_timer_counter.sv
module cap_timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uflow_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '1;
    else if (dec_i) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o   = cnt_q;
  assign uflow_o = dec_i & (cnt_q == '0);
endmodule

// File: rtl/cap_timer_capreg.sv
module cap_timer_capreg #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] d_i,
  output logic [CNT_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_a_o,
  output logic [CNT_W-1:0] cap_b_o,
  output logic             irq_o
);
  localparam int NPIN = 2;

  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [NPIN-1:0]  pin_v, rise, fall, trig, cap_ld;
  logic [CNT_W-1:0] cap_v [NPIN];
  logic             dec, uflow, in_cap, in_evt;
  mode_kind_e       kind;

  assign pin_v  = {pin_b_i, pin_a_i};
  assign kind   = decode_mode(ctl_q[2:0]);
  assign in_cap = (kind == MK_CAPTURE);
  assign in_evt = (kind == MK_EVENT);

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    cap_timer_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_v[g]),
      .rise_o(rise[g]),
      .fall_o(fall[g])
    );
    // pin A polarity in mode bit 1, pin B in mode bit 0
    assign trig[g]   = ctl_q[1-g] ? fall[g] : rise[g];
    assign cap_ld[g] = in_cap & trig[g];

    cap_timer_capreg #(.CNT_W(CNT_W)) u_cap (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(cap_ld[g]),
      .d_i   (cnt_o),
      .q_o   (cap_v[g])
    );
  end

  assign cap_a_o = cap_v[0];
  assign cap_b_o = cap_v[1];

  assign dec = in_cap | (in_evt & ctl_q[B_RUN] & rise[0]);

  cap_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (dec),
    .cnt_o  (cnt_o),
    .uflow_o(uflow)
  );

  // set events win over a same-cycle software write
  always_comb begin
    ctl_d = ctl_we_i ? ctl_wdata_i : ctl_q;
    if (cap_ld[0])                    ctl_d[B_PN_A] = 1'b1;
    if (cap_ld[1] | (in_evt & rise[1])) ctl_d[B_PN_B] = 1'b1;
    if (in_cap & uflow)               ctl_d[B_RUN]  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
  assign irq_o = (ctl_q[B_EN_A] & (ctl_q[B_PN_A] | (in_cap & ctl_q[B_RUN])))
               | (ctl_q[B_EN_B] & ctl_q[B_PN_B]);
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctl_we_i,
  input logic [CTL_W-1:0] ctl_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] cap_a_o,
  input logic [CNT_W-1:0] cap_b_o,
  input logic             irq_o
);
  mode_kind_e kind;
  assign kind = decode_mode(ctl_o[2:0]);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == MK_IDLE) |=> $stable(cnt_o));

  p_evt_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == MK_EVENT && !ctl_o[B_RUN]) |=> $stable(cnt_o));

  p_free_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == MK_CAPTURE) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));

  p_cap_a_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind != MK_CAPTURE) |=> $stable(cap_a_o));

  p_cap_b_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind != MK_CAPTURE) |=> $stable(cap_b_o));

  p_uflow_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == MK_CAPTURE && cnt_o == '0) |=> ctl_o[B_RUN]);

  p_pend_a_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[B_PN_A] && !ctl_we_i) |=> ctl_o[B_PN_A]);

  p_pend_b_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[B_PN_B] && !ctl_we_i) |=> ctl_o[B_PN_B]);

  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_o[B_EN_A] && !ctl_o[B_EN_B]) |-> !irq_o);
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ctl_we_i(ctl_we_i),
  .ctl_o   (ctl_o),
  .cnt_o   (cnt_o),
  .cap_a_o (cap_a_o),
  .cap_b_o (cap_b_o),
  .irq_o   (irq_o)
);

// File: tb/cap_timer_bench.sv
`timescale 1ns/1ps
module cap_timer_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pin_a = 1'b0, pin_b = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   ctl;
  logic [W-1:0] cnt, cap_a, cap_b;
  logic         irq;
  int           n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  cap_timer #(.CNT_W(W), .SYNC_STAGES(2)) u_cap_timer (
    .clk_i(clk), .rst_ni(rst_n), .pin_a_i(pin_a), .pin_b_i(pin_b),
    .ctl_we_i(we), .ctl_wdata_i(wdata), .ctl_o(ctl), .cnt_o(cnt),
    .cap_a_o(cap_a), .cap_b_o(cap_b), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_a(input int n);
    for (int i = 0; i < n; i++) begin
      pin_a = 1'b1; step(3);
      pin_a = 1'b0; step(3);
    end
  endtask

  // drive one pin to level lv, expect capture iff it is the selected edge
  task automatic cap_try(input int which, input logic lv, input logic pol, input logic [7:0] m);
    logic [W-1:0] v, prev;
    logic         hit;
    v    = cnt;
    prev = (which == 0) ? cap_a : cap_b;
    hit  = (pol == 1'b0) ? lv : ~lv;
    if (which == 0) pin_a = lv; else pin_b = lv;
    step(4);
    if (which == 0) begin
      chk("R6 cap_a value", int'(cap_a), hit ? int'(W'(v - W'(2))) : int'(prev));
      chk("R6 pend_a", int'(ctl[6]), int'(hit));
    end else begin
      chk("R7 cap_b value", int'(cap_b), hit ? int'(W'(v - W'(2))) : int'(prev));
      chk("R7 pend_b", int'(ctl[7]), int'(hit));
    end
    wr(m);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    step(2);
    rst_n = 1'b1;
    step(1);
    // R1
    chk("R1 cnt", int'(cnt), 255);
    chk("R1 ctl", int'(ctl), 0);
    chk("R1 caps", int'({cap_a, cap_b}), 0);
    chk("R1 irq", int'(irq), 0);

    // R2: idle modes 000 and 011
    pulse_a(3);
    pin_b = 1'b1; step(4); pin_b = 1'b0; step(4);
    chk("R2 cnt idle 000", int'(cnt), 255);
    chk("R2 no pending", int'(ctl), 0);
    wr(8'h0B);
    pulse_a(2);
    chk("R2 cnt idle 011", int'(cnt), 255);
    chk("R2 caps idle", int'({cap_a, cap_b}), 0);

    // R3: event counting sweep
    wr(8'h0A);
    begin
      int tot = 0;
      for (int n = 1; n <= 4; n++) begin
        pulse_a(n);
        tot += n;
        chk("R3 event count", int'(cnt), 255 - tot);
      end
      chk("R3 no pend_a in event", int'(ctl[6]), 0);
      wr(8'h02);
      pulse_a(3);
      chk("R3 stopped hold", int'(cnt), 255 - tot);
    end

    // R4, R10, R9: pin B in event mode
    pin_b = 1'b1; step(4); pin_b = 1'b0; step(2);
    chk("R4 pend_b set", int'(ctl[7]), 1);
    chk("R4 no cap_b", int'(cap_b), 0);
    chk("R10 irq masked", int'(irq), 0);
    wr(8'hA2);
    chk("R10 irq from pend_b", int'(irq), 1);
    wr(8'h22);
    chk("R9 pend_b cleared", int'(ctl[7]), 0);
    chk("R10 irq low after clear", int'(irq), 0);

    // R5: free running in capture mode
    wr(8'h04);
    v = cnt;
    step(10);
    chk("R5 free run", int'(cnt), int'(W'(v - W'(10))));

    // R6, R7: polarity sweep over all capture modes
    for (int m = 4; m < 8; m++) begin
      logic [7:0] mv;
      mv = 8'(m);
      wr(mv);
      cap_try(0, 1'b1, mv[1], mv);
      cap_try(0, 1'b0, mv[1], mv);
      cap_try(1, 1'b1, mv[0], mv);
      cap_try(1, 1'b0, mv[0], mv);
    end

    // R8, R10: underflow flag and its interrupt
    wr(8'h14);
    v = cnt;
    step(int'(v) + 3);
    chk("R8 underflow flag", int'(ctl[3]), 1);
    chk("R10 irq from underflow", int'(irq), 1);
    chk("R5 wrapped", int'(cnt), int'(W'(v - W'(int'(v) + 3))));
    wr(8'h14);
    chk("R9 underflow flag cleared", int'(ctl[3]), 0);
    chk("R10 irq low", int'(irq), 0);

    // R9: capture in the same cycle as a clearing write
    wr(8'h04);
    pin_a = 1'b1;
    step(2);
    wr(8'h04);
    chk("R9 set wins over write", int'(ctl[6]), 1);
    step(20);
    chk("R9 pend_a latched", int'(ctl[6]), 1);
    pin_a = 1'b0;
    step(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule